// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor

This block is a small one-address processor built around a single 16-bit accumulator. Each instruction names at most one memory operand. The accumulator is both the implicit source and the implicit destination of every arithmetic operation. The processor reaches a word-wide external memory through an address register and a data register. A read strobe and a write strobe mark each access, and every access takes the full memory budget.

Each instruction runs through fixed micro-steps, and each step has a fixed cycle cost. The fetch phase copies the program counter into the address register, reads memory, advances the counter by two and moves the fetched word into the instruction register. Decode follows. For an instruction with an operand, the address register takes the operand address from the instruction and the access takes place. The accumulator is then updated. A stop instruction parks the sequencer and raises a halted flag, which stays set until the next reset. The cycle counts are deterministic, so a system around this block can plan its memory traffic in advance.

Top module: `acc_cpu`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the accumulator reads zero, halted is low and both strobes are low. The first read access goes to address 0.
- R2: An instruction word is laid out as follows. Bits [15:13] hold the opcode: 000 stop, 001 load, 010 store, 011 add, 100 subtract, 101 multiply. Bits [9:0] hold the operand address. Bits [12:10] are ignored.
- R3: Instruction fetches go to the program counter, which starts at 0 and advances by 2 per instruction. Operand reads go to the address in bits [9:0] of the instruction.
- R4: Every memory access keeps its strobe high for exactly 10 consecutive cycles, with the address held steady throughout. Read and write are never asserted together.
- R5: Load sets the accumulator to the memory word at the operand address.
- R6: Add sets the accumulator to the accumulator plus the memory operand, and subtract sets it to the accumulator minus the memory operand. Both wrap modulo 2^16.
- R7: Multiply keeps the low 16 bits of the accumulator times the memory operand.
- R8: Store drives the accumulator on the write data bus at the operand address for the whole 10-cycle write. The accumulator does not change.
- R9: Each instruction costs a fixed number of cycles. Fetch costs 13 (transfer 1, memory 10, increment 1, transfer 1) and decode costs 2. Load totals 27, store 26, add and subtract 28, multiply 31 and stop 15.
- R10: After a stop, halted goes high and stays high, and no further memory access of any kind is started until reset.
- R11: Opcodes 110 and 111 behave exactly like stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 10 | Memory address, driven from the address register |
| mem_re | output | 1 | Read strobe, high for each cycle of a read access |
| mem_we | output | 1 | Write strobe, high for each cycle of a write access |
| mem_wdata | output | 16 | Write data (the accumulator) |
| mem_rdata | input | 16 | Read data from memory, sampled in the last cycle of a read |
| acc_out | output | 16 | Current accumulator value |
| halted | output | 1 | High once a stop-class instruction has been decoded |

## Verification
The bench runs short programs and measures the number of cycles from reset to halt. This catches a sequencer that shortens or stretches a single micro-step, such as a 9-cycle read or a 4-cycle multiply, because the totals then come out wrong. The arithmetic tests push values past the 16-bit limit on add, subtract and multiply. A design that drops the wrap, reverses the subtract operands or keeps the wrong half of the product stores a wrong word. The bench times every strobe pulse and records the address of each read. A design that ends an access early, moves the address during an access or advances the program counter by one is therefore visible at the ports. Stop, and the two undefined opcodes, are run with junk in the ignored bits. The bench then watches the bus for a long stretch, so any fetch after a halt is caught.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int unsigned DATA_W_DEF  = 16;
    localparam int unsigned ADDR_W_DEF  = 10;
    localparam int unsigned OP_W        = 3;
    localparam int unsigned MEM_CYC_DEF = 10;
    localparam int unsigned DEC_CYC_DEF = 2;
    localparam int unsigned ADD_CYC_DEF = 2;
    localparam int unsigned MUL_CYC_DEF = 5;
    localparam int unsigned PC_STEP_DEF = 2;

    typedef enum logic [OP_W-1:0] {
        OPC_HALT = 3'd0,
        OPC_LOAD = 3'd1,
        OPC_STOR = 3'd2,
        OPC_ADD  = 3'd3,
        OPC_SUB  = 3'd4,
        OPC_MUL  = 3'd5
    } opcode_e;

    typedef enum logic [3:0] {
        SQ_FADDR,
        SQ_FREAD,
        SQ_PCINC,
        SQ_IRLD,
        SQ_DECODE,
        SQ_OADDR,
        SQ_OREAD,
        SQ_OWRITE,
        SQ_EXEC,
        SQ_PARK
    } seq_state_e;

    typedef enum logic [1:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_SUB,
        ALU_MUL
    } alu_op_e;

    typedef struct packed {
        logic    mar_from_pc;
        logic    mar_from_ir;
        logic    mdr_load;
        logic    pc_inc;
        logic    ir_load;
        logic    acc_load;
        alu_op_e alu_op;
        logic    mem_re;
        logic    mem_we;
        logic    halted;
    } ctrl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int unsigned W = DATA_W_DEF
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] opnd_i,
    output logic [W-1:0] res_o
);

    always_comb begin
        unique case (op_i)
            ALU_ADD: res_o = acc_i + opnd_i;
            ALU_SUB: res_o = acc_i - opnd_i;
            ALU_MUL: res_o = acc_i * opnd_i;
            default: res_o = opnd_i;
        endcase
    end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
#(
    parameter int unsigned MEM_CYC = MEM_CYC_DEF,
    parameter int unsigned DEC_CYC = DEC_CYC_DEF,
    parameter int unsigned ADD_CYC = ADD_CYC_DEF,
    parameter int unsigned MUL_CYC = MUL_CYC_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [OP_W-1:0] op_i,
    output ctrl_t           ctl_o
);

    localparam int unsigned MAX_A   = (MEM_CYC > DEC_CYC) ? MEM_CYC : DEC_CYC;
    localparam int unsigned MAX_B   = (ADD_CYC > MUL_CYC) ? ADD_CYC : MUL_CYC;
    localparam int unsigned MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t             seq_d, seq_q;
    opcode_e          opc;
    logic [CNT_W-1:0] exec_last;
    alu_op_e          alu_sel;
    logic             has_opnd;

    assign opc = opcode_e'(op_i);

    always_comb begin
        has_opnd  = 1'b1;
        alu_sel   = ALU_PASS;
        exec_last = '0;
        unique case (opc)
            OPC_LOAD: alu_sel = ALU_PASS;
            OPC_STOR: alu_sel = ALU_PASS;
            OPC_ADD: begin
                alu_sel   = ALU_ADD;
                exec_last = CNT_W'(ADD_CYC - 1);
            end
            OPC_SUB: begin
                alu_sel   = ALU_SUB;
                exec_last = CNT_W'(ADD_CYC - 1);
            end
            OPC_MUL: begin
                alu_sel   = ALU_MUL;
                exec_last = CNT_W'(MUL_CYC - 1);
            end
            default: has_opnd = 1'b0;
        endcase
    end

    always_comb begin
        seq_d        = seq_q;
        ctl_o        = '0;
        ctl_o.alu_op = alu_sel;
        unique case (seq_q.st)
            SQ_FADDR: begin
                ctl_o.mar_from_pc = 1'b1;
                seq_d.st          = SQ_FREAD;
                seq_d.cnt         = CNT_W'(MEM_CYC - 1);
            end
            SQ_FREAD: begin
                ctl_o.mem_re = 1'b1;
                if (seq_q.cnt == '0) begin
                    ctl_o.mdr_load = 1'b1;
                    seq_d.st       = SQ_PCINC;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            SQ_PCINC: begin
                ctl_o.pc_inc = 1'b1;
                seq_d.st     = SQ_IRLD;
            end
            SQ_IRLD: begin
                ctl_o.ir_load = 1'b1;
                seq_d.st      = SQ_DECODE;
                seq_d.cnt     = CNT_W'(DEC_CYC - 1);
            end
            SQ_DECODE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.st = has_opnd ? SQ_OADDR : SQ_PARK;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            SQ_OADDR: begin
                ctl_o.mar_from_ir = 1'b1;
                seq_d.st          = (opc == OPC_STOR) ? SQ_OWRITE : SQ_OREAD;
                seq_d.cnt         = CNT_W'(MEM_CYC - 1);
            end
            SQ_OREAD: begin
                ctl_o.mem_re = 1'b1;
                if (seq_q.cnt == '0) begin
                    ctl_o.mdr_load = 1'b1;
                    seq_d.st       = SQ_EXEC;
                    seq_d.cnt      = exec_last;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            SQ_EXEC: begin
                if (seq_q.cnt == '0) begin
                    ctl_o.acc_load = 1'b1;
                    seq_d.st       = SQ_FADDR;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            SQ_OWRITE: begin
                ctl_o.mem_we = 1'b1;
                if (seq_q.cnt == '0) begin
                    seq_d.st = SQ_FADDR;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: begin
                ctl_o.halted = 1'b1;
                seq_d.st     = SQ_PARK;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q.st  <= SQ_FADDR;
            seq_q.cnt <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    // R4
    re_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_o.mem_re && ctl_o.mem_we));

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o.halted |=> ctl_o.halted);

    // R10
    halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_o.halted |-> (!ctl_o.mem_re && !ctl_o.mem_we && !ctl_o.ir_load));

endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
    import acc_cpu_pkg::*;
#(
    parameter int unsigned DATA_W  = DATA_W_DEF,
    parameter int unsigned ADDR_W  = ADDR_W_DEF,
    parameter int unsigned PC_STEP = PC_STEP_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctrl_t             ctl_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic [OP_W-1:0]   op_o,
    output logic [ADDR_W-1:0] mar_o,
    output logic [DATA_W-1:0] acc_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        logic [OP_W-1:0]   ir_op;
        logic [ADDR_W-1:0] ir_addr;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mdr;
        logic [DATA_W-1:0] acc;
    } regs_t;

    regs_t             regs_d, regs_q;
    logic [DATA_W-1:0] alu_res;

    acc_cpu_alu #(.W(DATA_W)) u_alu (
        .op_i   (ctl_i.alu_op),
        .acc_i  (regs_q.acc),
        .opnd_i (regs_q.mdr),
        .res_o  (alu_res)
    );

    always_comb begin
        regs_d = regs_q;
        if (ctl_i.mar_from_pc) regs_d.mar = regs_q.pc;
        if (ctl_i.mar_from_ir) regs_d.mar = regs_q.ir_addr;
        if (ctl_i.mdr_load)    regs_d.mdr = rdata_i;
        if (ctl_i.pc_inc)      regs_d.pc  = regs_q.pc + ADDR_W'(PC_STEP);
        if (ctl_i.ir_load) begin
            regs_d.ir_op   = regs_q.mdr[DATA_W-1 -: OP_W];
            regs_d.ir_addr = regs_q.mdr[ADDR_W-1:0];
        end
        if (ctl_i.acc_load)    regs_d.acc = alu_res;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign op_o  = regs_q.ir_op;
    assign mar_o = regs_q.mar;
    assign acc_o = regs_q.acc;

    // R8
    st_acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_i.mem_we && $past(ctl_i.mem_we)) |-> $stable(regs_q.acc));

    // R3
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.pc_inc |=> (regs_q.pc == $past(regs_q.pc) + ADDR_W'(PC_STEP)));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int unsigned DATA_W  = DATA_W_DEF,
    parameter int unsigned ADDR_W  = ADDR_W_DEF,
    parameter int unsigned MEM_CYC = MEM_CYC_DEF,
    parameter int unsigned DEC_CYC = DEC_CYC_DEF,
    parameter int unsigned ADD_CYC = ADD_CYC_DEF,
    parameter int unsigned MUL_CYC = MUL_CYC_DEF,
    parameter int unsigned PC_STEP = PC_STEP_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] acc_out,
    output logic              halted
);

    ctrl_t           ctl;
    logic [OP_W-1:0] ir_op;
    logic [DATA_W-1:0] acc;

    acc_cpu_ctrl #(
        .MEM_CYC (MEM_CYC),
        .DEC_CYC (DEC_CYC),
        .ADD_CYC (ADD_CYC),
        .MUL_CYC (MUL_CYC)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .op_i  (ir_op),
        .ctl_o (ctl)
    );

    acc_cpu_dp #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .PC_STEP (PC_STEP)
    ) u_dp (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_i   (ctl),
        .rdata_i (mem_rdata),
        .op_o    (ir_op),
        .mar_o   (mem_addr),
        .acc_o   (acc)
    );

    assign mem_re    = ctl.mem_re;
    assign mem_we    = ctl.mem_we;
    assign mem_wdata = acc;
    assign acc_out   = acc;
    assign halted    = ctl.halted;

    // R4
    access_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_re && $past(mem_re)) || (mem_we && $past(mem_we))) |-> $stable(mem_addr));

endmodule

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  mem_addr;
    logic        mem_re, mem_we;
    logic [15:0] mem_wdata, mem_rdata, acc_out;
    logic        halted;

    logic [15:0] mem [0:1023];
    int          total = 0;
    int          fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_cpu dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_re    (mem_re),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .acc_out   (acc_out),
        .halted    (halted)
    );

    assign mem_rdata = mem[mem_addr];
    always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

    // bus monitor: pulse lengths, address/data stability, read address log
    int          re_rises, re_bad, we_rises, we_bad, re_run, we_run;
    logic        prev_re, prev_we;
    logic [9:0]  re_a0, we_a0;
    logic [15:0] we_d0;
    logic [9:0]  rd_log [0:31];

    always @(negedge clk) begin
        if (!rst_n) begin
            re_rises = 0; re_bad = 0; we_rises = 0; we_bad = 0;
            re_run = 0; we_run = 0; prev_re = 1'b0; prev_we = 1'b0;
        end else begin
            if (mem_re) begin
                if (!prev_re) begin
                    rd_log[re_rises % 32] = mem_addr;
                    re_rises++; re_run = 1; re_a0 = mem_addr;
                end else begin
                    re_run++;
                    if (mem_addr !== re_a0) re_bad++;
                end
            end else if (prev_re && re_run != 10) re_bad++;
            if (mem_we) begin
                if (!prev_we) begin
                    we_rises++; we_run = 1; we_a0 = mem_addr; we_d0 = mem_wdata;
                end else begin
                    we_run++;
                    if (mem_addr !== we_a0 || mem_wdata !== we_d0) we_bad++;
                end
            end else if (prev_we && we_run != 10) we_bad++;
            if (mem_re && mem_we) re_bad++;
            prev_re = mem_re; prev_we = mem_we;
        end
    end

    function automatic logic [15:0] enc(input logic [2:0] op, input logic [9:0] a,
                                        input logic [2:0] junk);
        return {op, junk, a};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
    endtask

    // releases reset and returns the number of rising edges until halted
    task automatic run(output int n);
        n = 0;
        rst_n = 1'b1;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (halted || n > 3000) break;
        end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 acc in reset", acc_out, 0);
        chk("R1 halted in reset", halted, 0);
        chk("R1 strobes in reset", {mem_re, mem_we}, 0);
        rst_n = 1'b1;
        chk("R1 acc after release", acc_out, 0);
        chk("R1 no strobe first cycle", {mem_re, mem_we}, 0);
        @(posedge clk); @(negedge clk);
        chk("R1 first read strobe", mem_re, 1);
        chk("R1 first read address", mem_addr, 0);
    endtask

    task automatic t_load_store();
        int n;
        do_reset();
        mem[0] = enc(3'b001, 10'h100, 3'b000);
        mem[2] = enc(3'b010, 10'h101, 3'b000);
        mem[4] = enc(3'b000, 10'h000, 3'b000);
        mem[10'h100] = 16'h1234;
        run(n);
        chk("R9 load+store+stop cycles", n, 27 + 26 + 15);
        chk("R5 load value", acc_out, 16'h1234);
        chk("R8 stored word", mem[10'h101], 16'h1234);
        chk("R8 acc unchanged by store", acc_out, 16'h1234);
        chk("R8 one write pulse", we_rises, 1);
        chk("R8 write pulse 10 cycles, steady", we_bad, 0);
        chk("R4 read pulses 10 cycles, steady", re_bad, 0);
        chk("R3 read count", re_rises, 4);
        chk("R3 fetch 0", rd_log[0], 10'h000);
        chk("R3 operand addr", rd_log[1], 10'h100);
        chk("R3 fetch 2", rd_log[2], 10'h002);
        chk("R3 fetch 4", rd_log[3], 10'h004);
    endtask

    task automatic t_expr();
        int n;
        logic [15:0] x, y, e;
        x = 16'd300; y = 16'd200;
        e = 16'((x + y) * (x - y));
        do_reset();
        mem[0]  = enc(3'b001, 10'h200, 3'b000);
        mem[2]  = enc(3'b011, 10'h202, 3'b101);
        mem[4]  = enc(3'b010, 10'h204, 3'b000);
        mem[6]  = enc(3'b001, 10'h200, 3'b111);
        mem[8]  = enc(3'b100, 10'h202, 3'b000);
        mem[10] = enc(3'b101, 10'h204, 3'b010);
        mem[12] = enc(3'b010, 10'h206, 3'b000);
        mem[14] = enc(3'b000, 10'h000, 3'b000);
        mem[10'h200] = x; mem[10'h202] = y;
        run(n);
        chk("R9 expression cycles", n, 27 + 28 + 26 + 27 + 28 + 31 + 26 + 15);
        chk("R6 sum stored", mem[10'h204], 16'(x + y));
        chk("R7 product stored", mem[10'h206], e);
        chk("R2 junk bits ignored, acc", acc_out, e);
        chk("R4 expression access pulses", re_bad + we_bad, 0);
    endtask

    task automatic t_wrap();
        int n;
        logic [15:0] a, b, c, d, s1, s2;
        a = 16'hFFF0; b = 16'h0020; c = 16'h0030; d = 16'h0100;
        s1 = a + b - c;
        s2 = s1 * d;
        do_reset();
        mem[0]  = enc(3'b001, 10'h300, 3'b000);
        mem[2]  = enc(3'b011, 10'h302, 3'b000);
        mem[4]  = enc(3'b100, 10'h304, 3'b000);
        mem[6]  = enc(3'b010, 10'h30A, 3'b000);
        mem[8]  = enc(3'b101, 10'h306, 3'b000);
        mem[10] = enc(3'b010, 10'h308, 3'b000);
        mem[12] = enc(3'b000, 10'h000, 3'b000);
        mem[10'h300] = a; mem[10'h302] = b; mem[10'h304] = c; mem[10'h306] = d;
        run(n);
        chk("R9 wrap program cycles", n, 27 + 28 + 28 + 26 + 31 + 26 + 15);
        chk("R6 add/sub wrap", mem[10'h30A], s1);
        chk("R7 multiply low half", mem[10'h308], s2);
        chk("R7 acc after multiply", acc_out, s2);
    endtask

    task automatic t_halt(input logic [2:0] op, input string req);
        int n;
        do_reset();
        mem[0] = enc(op, 10'h155, 3'b110);
        mem[2] = enc(3'b001, 10'h010, 3'b000);
        run(n);
        chk({req, " stop cycles"}, n, 15);
        repeat (60) @(negedge clk);
        chk({req, " halted stays high"}, halted, 1);
        chk({req, " only the fetch read"}, re_rises, 1);
        chk({req, " no write after halt"}, we_rises, 0);
        chk({req, " acc untouched"}, acc_out, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_reset();
        t_load_store();
        t_expr();
        t_wrap();
        t_halt(3'b000, "R10");
        t_halt(3'b110, "R11 op110");
        t_halt(3'b111, "R11 op111");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule